// File: doc/BRIEF.md
# SPI Opcode Sequencer Engine

This block is the control core of a SPI controller. It executes a short program of eight 8-bit opcodes, one slot after the other, and drives a separate shift engine through a request/done handshake. The program can select and deselect the single attached responder and request N1 and N2 shift segments. It can also branch on a masked comparison of the low receive-data bits, and it has two counted loop branches. Serialization, bit clocking and ECC belong to the shift engine and to the rest of the controller.

A start pulse runs the program. The surrounding controller raises it when software writes the transmit register, or when it reads the receive register while the shifter is waiting. If the sequencer is idle, the program starts from slot 0. If a stall paused it, the program resumes at the slot that stalled. Status outputs expose the sequencer state, the current slot index, the shifter state and an error flag. The `rst_n` input is asserted asynchronously and is released through an internal two-flop synchronizer.

Top module: `spi_seq_engine`

## Requirements
- R1: A start pulse while the sequencer is idle (seq state 0) clears the error flag, sets the index to 0 and enters run (seq state 1). In run, one opcode is executed per clock edge. When the index advances past slot 7, the sequencer returns to idle and the index reads 8.
- R2: Only opcode bits [7:4] pick the operation: 0x0 stop, 0x1 select, 0x3 shift-N1, 0x4 shift-N2, 0x6 RDR branch, 0xE loop A, 0xF loop B. Any other upper nibble is a no-op that advances the index.
- R3: A stop returns the sequencer to idle and the shifter to idle (shifter state 0), and it clears both loop counters.
- R4: Opcode 0x10 drives the responder select to 0, sets the shifter to done (state 5) and advances. Opcode 0x11 drives the select to 1, sets the shifter to start (state 1), clears the N1-completed flag and advances. Any other select low nibble sets the error flag, idles the shifter and idles the sequencer.
- R5: A shift-N1 executed while the shifter is idle or done sets the error flag and idles the sequencer.
- R6: A shift-N2 executed with no shift-N1 completed since the last select sets the error flag and idles the sequencer.
- R7: A shift that is issued pulses the shift request for one cycle and moves the sequencer to shift-wait (state 2) and the shifter to N1 (2) or N2 (3). The N2 flag tells the two shifts apart. The merge flag is raised on an N1 whose next slot has upper nibble 0x4. The last flag is raised when the next slot holds 0x10. The index advances on the edge that samples shift-done.
- R8: A shift executed while the TDR is empty or the RDR is full issues no request. It sets the shifter to wait (4) and the sequencer to paused (3), and it keeps the index. A later start re-executes the same slot.
- R9: The RDR branch (upper nibble 0x6) executed without RDR-full sets the shifter to wait and pauses. With RDR-full it pulses the RDR-clear output, then advances on a match or jumps to opcode bits [2:0] on a mismatch.
- R10: The RDR comparison takes the low 16 receive bits. Mask bits set to 1 are ignored, and mask bits set to 0 must equal the match value.
- R11: Loop A (0xE) and loop B (0xF) each compare their own counter with their own compare input. If the values differ, the sequencer jumps to opcode bits [2:0] and the counter increments. If they are equal, the index advances.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start or resume pulse |
| prog_i | input | NSLOT*8 (64) | Program; slot i at bits [8i+7:8i] |
| rdr_low_i | input | RDW (16) | Low receive-data bits |
| match_val_i | input | RDW (16) | Branch match value |
| match_mask_i | input | RDW (16) | Branch mask, 1 = ignore bit |
| loop_cmp_a_i | input | LCW (4) | Loop A compare value |
| loop_cmp_b_i | input | LCW (4) | Loop B compare value |
| rdr_full_i | input | 1 | Receive register holds unread data |
| tdr_empty_i | input | 1 | Transmit register has no data |
| shift_done_i | input | 1 | Shift engine finished the request |
| shift_req_o | output | 1 | One-cycle shift request |
| shift_n2_o | output | 1 | Request is an N2 segment |
| shift_merge_o | output | 1 | N1 is merged with the following N2 |
| shift_last_o | output | 1 | Last shift before deselect |
| rdr_clr_o | output | 1 | One-cycle pulse clearing RDR-full |
| resp_sel_o | output | 1 | Responder selected |
| seq_state_o | output | 2 | 0 idle, 1 run, 2 shift-wait, 3 paused |
| seq_idx_o | output | IDXW (4) | Current slot index |
| shf_state_o | output | 3 | 0 idle, 1 start, 2 N1, 3 N2, 4 wait, 5 done |
| err_o | output | 1 | Sequencer error flag |

## Verification
A start pulse takes effect on the first clock edge. Each following edge executes one slot, so the state after k opcodes is due k edges after that first edge. The directed tasks count those edges exactly and sample on the falling edge between them. Shift requests appear on the edge that executes the shift opcode. The bench's responder model answers two cycles later, and the index moves on the edge that sees done. The shift-based tasks therefore check the request flags as they are logged, and they wait for idle with a bounded poll.

// File: rtl/spi_seq_pkg.sv
package spi_seq_pkg;
  localparam int OPW = 8;

  typedef enum logic [1:0] {
    SQ_IDLE  = 2'd0,
    SQ_RUN   = 2'd1,
    SQ_SHIFT = 2'd2,
    SQ_PAUSE = 2'd3
  } seq_st_e;

  typedef enum logic [2:0] {
    SH_IDLE  = 3'd0,
    SH_START = 3'd1,
    SH_N1    = 3'd2,
    SH_N2    = 3'd3,
    SH_WAIT  = 3'd4,
    SH_DONE  = 3'd5
  } shf_st_e;

  typedef enum logic [2:0] {
    K_NOP, K_STOP, K_SEL, K_N1, K_N2, K_BRR, K_LOOPA, K_LOOPB
  } op_kind_e;

  localparam logic [3:0] NIB_STOP = 4'h0;
  localparam logic [3:0] NIB_SEL  = 4'h1;
  localparam logic [3:0] NIB_N1   = 4'h3;
  localparam logic [3:0] NIB_N2   = 4'h4;
  localparam logic [3:0] NIB_BRR  = 4'h6;
  localparam logic [3:0] NIB_LPA  = 4'hE;
  localparam logic [3:0] NIB_LPB  = 4'hF;
  localparam logic [OPW-1:0] OP_DESEL = 8'h10;
endpackage

// File: rtl/seq_rst_sync.sv
module seq_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sn
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sn = sync_q[1];
endmodule

// File: rtl/seq_op_decode.sv
module seq_op_decode
  import spi_seq_pkg::*;
#(
  parameter int TW = 3
) (
  input  logic [OPW-1:0] op_i,
  input  logic [OPW-1:0] nxt_op_i,
  input  logic           has_next_i,
  output op_kind_e       kind_o,
  output logic [3:0]     sub_o,
  output logic [TW-1:0]  target_o,
  output logic           merge_o,
  output logic           last_o
);
  always_comb begin
    unique case (op_i[7:4])
      NIB_STOP: kind_o = K_STOP;
      NIB_SEL:  kind_o = K_SEL;
      NIB_N1:   kind_o = K_N1;
      NIB_N2:   kind_o = K_N2;
      NIB_BRR:  kind_o = K_BRR;
      NIB_LPA:  kind_o = K_LOOPA;
      NIB_LPB:  kind_o = K_LOOPB;
      default:  kind_o = K_NOP;
    endcase
    sub_o    = op_i[3:0];
    target_o = op_i[TW-1:0];
    merge_o  = has_next_i && (nxt_op_i[7:4] == NIB_N2);
    last_o   = has_next_i && (nxt_op_i == OP_DESEL);
  end
endmodule

// File: rtl/seq_rdr_match.sv
module seq_rdr_match #(
  parameter int RDW = 16
) (
  input  logic [RDW-1:0] data_i,
  input  logic [RDW-1:0] val_i,
  input  logic [RDW-1:0] mask_i,
  output logic           hit_o
);
  logic [RDW-1:0] diff;

  always_comb begin
    diff  = (data_i ^ val_i) & ~mask_i;
    hit_o = (diff == '0);
  end
endmodule

// File: rtl/seq_loop_bank.sv
module seq_loop_bank #(
  parameter int NLOOP = 2,
  parameter int LCW   = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clr_i,
  input  logic [NLOOP-1:0]     inc_i,
  input  logic [NLOOP*LCW-1:0] cmp_i,
  output logic [NLOOP-1:0]     eq_o
);
  for (genvar g = 0; g < NLOOP; g++) begin : g_ctr
    logic [LCW-1:0] cnt_q;
    logic [LCW-1:0] cnt_d;
    logic           cnt_en;

    always_comb begin
      cnt_en = clr_i || inc_i[g];
      cnt_d  = clr_i ? '0 : cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cnt_q <= '0;
      else if (cnt_en) cnt_q <= cnt_d;
    end

    assign eq_o[g] = (cnt_q == cmp_i[g*LCW +: LCW]);

    // R11: a loop counter only steps by one or returns to zero
    assert_loop_step_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_q != $past(cnt_q)) |-> ((cnt_q == $past(cnt_q) + 1'b1) || (cnt_q == '0)));
  end
endmodule

// File: rtl/spi_seq_engine.sv
module spi_seq_engine
  import spi_seq_pkg::*;
#(
  parameter int NSLOT = 8,
  parameter int RDW   = 16,
  parameter int LCW   = 4,
  localparam int TW   = $clog2(NSLOT),
  localparam int IDXW = TW + 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start_i,
  input  logic [NSLOT*OPW-1:0] prog_i,
  input  logic [RDW-1:0]       rdr_low_i,
  input  logic [RDW-1:0]       match_val_i,
  input  logic [RDW-1:0]       match_mask_i,
  input  logic [LCW-1:0]       loop_cmp_a_i,
  input  logic [LCW-1:0]       loop_cmp_b_i,
  input  logic                 rdr_full_i,
  input  logic                 tdr_empty_i,
  input  logic                 shift_done_i,
  output logic                 shift_req_o,
  output logic                 shift_n2_o,
  output logic                 shift_merge_o,
  output logic                 shift_last_o,
  output logic                 rdr_clr_o,
  output logic                 resp_sel_o,
  output logic [1:0]           seq_state_o,
  output logic [IDXW-1:0]      seq_idx_o,
  output logic [2:0]           shf_state_o,
  output logic                 err_o
);
  localparam int NLOOP = 2;

  logic rst_sn;
  seq_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_sn(rst_sn));

  // state registers
  seq_st_e        seq_q, seq_d;
  shf_st_e        shf_q, shf_d;
  logic [IDXW-1:0] idx_q, idx_d;
  logic           err_q, err_d;
  logic           n1ok_q, n1ok_d;
  logic           sel_q, sel_d;
  logic           req_q, req_d;
  logic           n2_q, n2_d;
  logic           mrg_q, mrg_d;
  logic           lst_q, lst_d;
  logic           clr_q, clr_d;

  // slot fetch
  logic [TW-1:0]  slot;
  logic [TW-1:0]  slot_nxt;
  logic           has_next;
  logic [OPW-1:0] cur_op;
  logic [OPW-1:0] nxt_op;

  always_comb begin
    slot     = idx_q[TW-1:0];
    slot_nxt = slot + 1'b1;
    has_next = (slot != TW'(NSLOT - 1));
    cur_op   = prog_i[int'(slot)*OPW +: OPW];
    nxt_op   = prog_i[int'(slot_nxt)*OPW +: OPW];
  end

  op_kind_e      kind;
  logic [3:0]    sub;
  logic [TW-1:0] target;
  logic          dec_merge;
  logic          dec_last;

  seq_op_decode #(.TW(TW)) u_dec (
    .op_i(cur_op), .nxt_op_i(nxt_op), .has_next_i(has_next),
    .kind_o(kind), .sub_o(sub), .target_o(target),
    .merge_o(dec_merge), .last_o(dec_last)
  );

  logic rdr_hit;
  seq_rdr_match #(.RDW(RDW)) u_match (
    .data_i(rdr_low_i), .val_i(match_val_i), .mask_i(match_mask_i),
    .hit_o(rdr_hit)
  );

  logic             loop_clr;
  logic [NLOOP-1:0] loop_inc;
  logic [NLOOP-1:0] loop_eq;
  seq_loop_bank #(.NLOOP(NLOOP), .LCW(LCW)) u_loops (
    .clk(clk), .rst_n(rst_sn), .clr_i(loop_clr), .inc_i(loop_inc),
    .cmp_i({loop_cmp_b_i, loop_cmp_a_i}), .eq_o(loop_eq)
  );

  // next index on advance and the end-of-table test
  logic [IDXW-1:0] idx_adv;
  logic            at_end;
  logic            stall;
  logic [0:0]      lsel;

  always_comb begin
    idx_adv = idx_q + 1'b1;
    at_end  = (idx_adv == IDXW'(NSLOT));
    stall   = tdr_empty_i || rdr_full_i;
    lsel    = (kind == K_LOOPB) ? 1'b1 : 1'b0;
  end

  // next-state logic
  always_comb begin
    seq_d    = seq_q;
    shf_d    = shf_q;
    idx_d    = idx_q;
    err_d    = err_q;
    n1ok_d   = n1ok_q;
    sel_d    = sel_q;
    req_d    = 1'b0;
    n2_d     = n2_q;
    mrg_d    = mrg_q;
    lst_d    = lst_q;
    clr_d    = 1'b0;
    loop_clr = 1'b0;
    loop_inc = '0;

    unique case (seq_q)
      SQ_IDLE: begin
        if (start_i) begin
          err_d = 1'b0;
          idx_d = '0;
          seq_d = SQ_RUN;
        end
      end
      SQ_PAUSE: begin
        if (start_i) begin
          err_d = 1'b0;
          seq_d = SQ_RUN;
        end
      end
      SQ_SHIFT: begin
        if (shift_done_i) begin
          idx_d = idx_adv;
          seq_d = at_end ? SQ_IDLE : SQ_RUN;
          if (shf_q == SH_N1) n1ok_d = 1'b1;
        end
      end
      SQ_RUN: begin
        unique case (kind)
          K_STOP: begin
            seq_d    = SQ_IDLE;
            shf_d    = SH_IDLE;
            n1ok_d   = 1'b0;
            loop_clr = 1'b1;
          end
          K_SEL: begin
            if (sub == 4'h0) begin
              sel_d  = 1'b0;
              shf_d  = SH_DONE;
              n1ok_d = 1'b0;
              idx_d  = idx_adv;
              if (at_end) seq_d = SQ_IDLE;
            end else if (sub == 4'h1) begin
              sel_d  = 1'b1;
              shf_d  = SH_START;
              n1ok_d = 1'b0;
              idx_d  = idx_adv;
              if (at_end) seq_d = SQ_IDLE;
            end else begin
              err_d = 1'b1;
              shf_d = SH_IDLE;
              seq_d = SQ_IDLE;
            end
          end
          K_N1, K_N2: begin
            if ((kind == K_N1) && ((shf_q == SH_IDLE) || (shf_q == SH_DONE))) begin
              err_d = 1'b1;
              seq_d = SQ_IDLE;
            end else if ((kind == K_N2) && !n1ok_q) begin
              err_d = 1'b1;
              seq_d = SQ_IDLE;
            end else if (stall) begin
              shf_d = SH_WAIT;
              seq_d = SQ_PAUSE;
            end else begin
              req_d = 1'b1;
              n2_d  = (kind == K_N2);
              mrg_d = (kind == K_N1) && dec_merge;
              lst_d = dec_last;
              shf_d = (kind == K_N2) ? SH_N2 : SH_N1;
              seq_d = SQ_SHIFT;
            end
          end
          K_BRR: begin
            if (!rdr_full_i) begin
              shf_d = SH_WAIT;
              seq_d = SQ_PAUSE;
            end else begin
              clr_d = 1'b1;
              if (rdr_hit) begin
                idx_d = idx_adv;
                if (at_end) seq_d = SQ_IDLE;
              end else begin
                idx_d = IDXW'(target);
              end
            end
          end
          K_LOOPA, K_LOOPB: begin
            if (!loop_eq[lsel]) begin
              idx_d          = IDXW'(target);
              loop_inc[lsel] = 1'b1;
            end else begin
              idx_d = idx_adv;
              if (at_end) seq_d = SQ_IDLE;
            end
          end
          default: begin
            idx_d = idx_adv;
            if (at_end) seq_d = SQ_IDLE;
          end
        endcase
      end
      default: seq_d = SQ_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      seq_q  <= SQ_IDLE;
      shf_q  <= SH_IDLE;
      idx_q  <= '0;
      err_q  <= 1'b0;
      n1ok_q <= 1'b0;
      sel_q  <= 1'b0;
      req_q  <= 1'b0;
      n2_q   <= 1'b0;
      mrg_q  <= 1'b0;
      lst_q  <= 1'b0;
      clr_q  <= 1'b0;
    end else begin
      seq_q  <= seq_d;
      shf_q  <= shf_d;
      idx_q  <= idx_d;
      err_q  <= err_d;
      n1ok_q <= n1ok_d;
      sel_q  <= sel_d;
      req_q  <= req_d;
      n2_q   <= n2_d;
      mrg_q  <= mrg_d;
      lst_q  <= lst_d;
      clr_q  <= clr_d;
    end
  end

  assign shift_req_o   = req_q;
  assign shift_n2_o    = n2_q;
  assign shift_merge_o = mrg_q;
  assign shift_last_o  = lst_q;
  assign rdr_clr_o     = clr_q;
  assign resp_sel_o    = sel_q;
  assign seq_state_o   = seq_q;
  assign seq_idx_o     = idx_q;
  assign shf_state_o   = shf_q;
  assign err_o         = err_q;

  // R1: while running, the index always points into the table
  assert_idx_in_table_R1: assert property (@(posedge clk) disable iff (!rst_sn)
    (seq_q == SQ_RUN) |-> (idx_q < IDXW'(NSLOT)));

  // R3: a stop executed in run leaves both machines idle
  assert_stop_idles_R3: assert property (@(posedge clk) disable iff (!rst_sn)
    ((seq_q == SQ_RUN) && (cur_op[7:4] == NIB_STOP)) |=>
      ((seq_state_o == 2'd0) && (shf_state_o == 3'd0)));

  // R5: a rising error flag always coincides with an idle sequencer
  assert_err_idles_R5: assert property (@(posedge clk) disable iff (!rst_sn)
    $rose(err_o) |-> (seq_state_o == 2'd0));

  // R6: an N2 request is only ever issued after a completed N1
  assert_n2_after_n1_R6: assert property (@(posedge clk) disable iff (!rst_sn)
    (shift_req_o && shift_n2_o) |-> n1ok_q);

  // R7: a request is only visible while waiting on the shift engine
  assert_req_in_shift_R7: assert property (@(posedge clk) disable iff (!rst_sn)
    shift_req_o |-> (seq_state_o == 2'd2));

  // R7: done seen in shift-wait advances the index by one
  assert_done_advances_R7: assert property (@(posedge clk) disable iff (!rst_sn)
    ((seq_q == SQ_SHIFT) && shift_done_i) |=> (seq_idx_o == $past(seq_idx_o) + 1'b1));

  // R9: the RDR clear pulse only follows a cycle with RDR-full set
  assert_clr_needs_full_R9: assert property (@(posedge clk) disable iff (!rst_sn)
    rdr_clr_o |-> $past(rdr_full_i));
endmodule

// File: tb/tb_spi_seq_engine.sv
module tb_spi_seq_engine;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [63:0] prog_i = '0;
  logic [15:0] rdr_low_i = '0;
  logic [15:0] match_val_i = '0;
  logic [15:0] match_mask_i = '0;
  logic [3:0]  loop_cmp_a_i = '0;
  logic [3:0]  loop_cmp_b_i = '0;
  logic        rdr_full_i = 1'b0;
  logic        tdr_empty_i = 1'b0;
  logic        shift_done_i;
  logic        shift_req_o, shift_n2_o, shift_merge_o, shift_last_o;
  logic        rdr_clr_o, resp_sel_o, err_o;
  logic [1:0]  seq_state_o;
  logic [3:0]  seq_idx_o;
  logic [2:0]  shf_state_o;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  spi_seq_engine dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .prog_i(prog_i),
    .rdr_low_i(rdr_low_i), .match_val_i(match_val_i), .match_mask_i(match_mask_i),
    .loop_cmp_a_i(loop_cmp_a_i), .loop_cmp_b_i(loop_cmp_b_i),
    .rdr_full_i(rdr_full_i), .tdr_empty_i(tdr_empty_i), .shift_done_i(shift_done_i),
    .shift_req_o(shift_req_o), .shift_n2_o(shift_n2_o), .shift_merge_o(shift_merge_o),
    .shift_last_o(shift_last_o), .rdr_clr_o(rdr_clr_o), .resp_sel_o(resp_sel_o),
    .seq_state_o(seq_state_o), .seq_idx_o(seq_idx_o), .shf_state_o(shf_state_o),
    .err_o(err_o)
  );

  // shift engine model: done two cycles after a request; logs request flags
  int       req_cnt = 0;
  int       clr_cnt = 0;
  int       rsp_cnt = 0;
  logic     log_n2 [8];
  logic     log_mrg[8];
  logic     log_lst[8];
  logic     done_r = 1'b0;
  assign shift_done_i = done_r;

  always @(negedge clk) begin
    done_r = 1'b0;
    if (rdr_clr_o) clr_cnt++;
    if (shift_req_o) begin
      log_n2[req_cnt % 8]  = shift_n2_o;
      log_mrg[req_cnt % 8] = shift_merge_o;
      log_lst[req_cnt % 8] = shift_last_o;
      req_cnt++;
      rsp_cnt = 2;
    end else if (rsp_cnt > 0) begin
      rsp_cnt--;
      if (rsp_cnt == 0) done_r = 1'b1;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic load(input logic [7:0] s0, s1, s2, s3, s4, s5, s6, s7);
    prog_i = {s7, s6, s5, s4, s3, s2, s1, s0};
  endtask

  // pulse start; returns at the falling edge after the edge that took it
  task automatic pulse_start();
    @(negedge clk);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic edges(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 200; i++) begin
      if (seq_state_o == 2'd0) break;
      @(negedge clk);
    end
  endtask

  task automatic t_reset();
    check("R1 reset seq state", seq_state_o, 0);
    check("R1 reset index", seq_idx_o, 0);
    check("R3 reset shifter", shf_state_o, 0);
    check("R1 reset err", err_o, 0);
    check("R7 reset req", shift_req_o, 0);
  endtask

  task automatic t_table_end();
    load(8'h20, 8'h21, 8'h2F, 8'h50, 8'h7A, 8'h8C, 8'h9B, 8'hD0);
    pulse_start();
    check("R1 run after start", seq_state_o, 1);
    check("R1 index 0 after start", seq_idx_o, 0);
    edges(7);
    check("R2 no-ops advance, still running", seq_state_o, 1);
    check("R2 index 7", seq_idx_o, 7);
    edges(1);
    check("R1 idle past slot 7", seq_state_o, 0);
    check("R1 index reads 8", seq_idx_o, 8);
  endtask

  task automatic t_shift_frame();
    int base = req_cnt;
    load(8'h11, 8'h30, 8'h40, 8'h10, 8'h00, 8'h00, 8'h00, 8'h00);
    pulse_start();
    edges(1);
    check("R4 select drives resp_sel", resp_sel_o, 1);
    check("R4 shifter start", shf_state_o, 1);
    edges(1);
    check("R7 request pulse", shift_req_o, 1);
    check("R7 shifter N1", shf_state_o, 2);
    check("R7 seq shift-wait", seq_state_o, 2);
    check("R7 index held during shift", seq_idx_o, 1);
    wait_idle();
    check("R7 two requests", req_cnt - base, 2);
    check("R7 N1 not N2", log_n2[base % 8], 0);
    check("R7 N1 merged with N2", log_mrg[base % 8], 1);
    check("R7 N1 not last", log_lst[base % 8], 0);
    check("R7 N2 flag", log_n2[(base + 1) % 8], 1);
    check("R7 N2 last before deselect", log_lst[(base + 1) % 8], 1);
    check("R4 deselect clears resp_sel", resp_sel_o, 0);
    check("R3 stop idles shifter", shf_state_o, 0);
    check("R3 stop index", seq_idx_o, 4);
    check("R6 no error on legal order", err_o, 0);
  endtask

  task automatic t_n1_err();
    load(8'h30, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00);
    pulse_start();
    edges(1);
    check("R5 N1 from idle shifter sets err", err_o, 1);
    check("R5 seq idle after error", seq_state_o, 0);
    check("R5 no request issued", shift_req_o, 0);
  endtask

  task automatic t_n2_err();
    load(8'h11, 8'h40, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00);
    pulse_start();
    check("R1 start clears err", err_o, 0);
    edges(2);
    check("R6 N2 without N1 sets err", err_o, 1);
    check("R6 seq idle", seq_state_o, 0);
    check("R6 index on failing slot", seq_idx_o, 1);
  endtask

  task automatic t_bad_select();
    load(8'h17, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00);
    pulse_start();
    edges(1);
    check("R4 bad select sets err", err_o, 1);
    check("R4 bad select idles shifter", shf_state_o, 0);
    check("R4 bad select idles seq", seq_state_o, 0);
  endtask

  task automatic t_stall();
    int base = req_cnt;
    load(8'h11, 8'h30, 8'h10, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00);
    tdr_empty_i = 1'b1;
    pulse_start();
    edges(2);
    check("R8 stall shifter wait", shf_state_o, 4);
    check("R8 stall seq paused", seq_state_o, 3);
    check("R8 stall keeps index", seq_idx_o, 1);
    check("R8 stall issues no request", req_cnt - base, 0);
    edges(3);
    check("R8 paused until restart", seq_state_o, 3);
    tdr_empty_i = 1'b0;
    pulse_start();
    check("R8 resume keeps index", seq_idx_o, 1);
    wait_idle();
    check("R8 resumed shift issued", req_cnt - base, 1);
    check("R7 last flag before deselect", log_lst[base % 8], 1);
    check("R7 no merge without N2", log_mrg[base % 8], 0);
    check("R8 run completes at stop", seq_idx_o, 3);
  endtask

  task automatic t_branch();
    int cbase;
    match_val_i  = 16'h1234;
    match_mask_i = 16'h00F0;
    load(8'h63, 8'h00, 8'h00, 8'h20, 8'h00, 8'h00, 8'h00, 8'h00);
    rdr_full_i = 1'b0;
    pulse_start();
    edges(1);
    check("R9 branch without RDR-full waits", shf_state_o, 4);
    check("R9 branch without RDR-full pauses", seq_state_o, 3);
    check("R9 index kept", seq_idx_o, 0);
    // match: bits differ only under the mask
    rdr_full_i = 1'b1;
    rdr_low_i  = 16'h12F4;
    cbase = clr_cnt;
    pulse_start();
    edges(2);
    check("R10 masked bits ignored, match advances", seq_idx_o, 1);
    check("R9 idle after stop", seq_state_o, 0);
    check("R9 RDR clear pulsed", clr_cnt - cbase, 1);
    // mismatch in an unmasked bit
    rdr_low_i = 16'h1334;
    pulse_start();
    edges(1);
    check("R10 unmasked difference jumps to target", seq_idx_o, 3);
    edges(2);
    check("R9 after jump ends at stop", seq_idx_o, 4);
    check("R9 idle", seq_state_o, 0);
    rdr_full_i = 1'b0;
  endtask

  task automatic t_loops();
    loop_cmp_a_i = 4'd3;
    load(8'hE0, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00);
    for (int pass = 0; pass < 2; pass++) begin
      pulse_start();
      edges(3);
      check("R11 loop A still jumping", seq_idx_o, 0);
      edges(1);
      check("R11 loop A equal advances", seq_idx_o, 1);
      check("R11 loop A running", seq_state_o, 1);
      edges(1);
      check("R3 stop after loop, counters cleared", seq_state_o, 0);
    end
    loop_cmp_b_i = 4'd0;
    load(8'hF2, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00);
    pulse_start();
    edges(2);
    check("R11 loop B equal advances", seq_idx_o, 1);
    loop_cmp_b_i = 4'd1;
    pulse_start();
    edges(2);
    check("R11 loop B differ jumps", seq_idx_o, 2);
    check("R11 loop B ends idle", seq_state_o, 0);
  endtask

  task automatic run_all();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_reset();
    t_table_end();
    t_shift_frame();
    t_n1_err();
    t_n2_err();
    t_bad_select();
    t_stall();
    t_branch();
    t_loops();
  endtask

  initial begin
    bit wd = 1'b0;
    fork
      run_all();
      begin
        repeat (100000) @(posedge clk);
        wd = 1'b1;
      end
    join_any
    disable fork;
    if (wd) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual expired expected completion");
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule